// File: doc/BRIEF.md
# Four-Channel PWM Timer

This block is a pulse-width modulation timer built around one free-running up-counter shared by four compare channels. A prescaler divides the input clock, and the counter then steps from zero up to a reload value and wraps. Each channel compares the counter with its own compare value to form a reference waveform. That waveform drives a main pin and, optionally, a complementary pin. Each pin has its own enable and its own polarity. One main-output gate turns every pin off at once.

Software sets up the timer through a small synchronous register port: a write strobe, an address and data, with read data returned combinationally for the current address. The prescaler and the compare values always go through shadow copies. The reload value can be shadowed or applied at once. A shadow copy moves into the active register when the counter wraps, or when software writes the update bit. The period is a single setting shared by all channels.

The counter is controlled by a two-state machine. In HALT the counter and prescaler hold their values. In RUN they advance. The GO transition (HALT to RUN) happens when the control register is written with the run bit set. The STOP transition (RUN to HALT) happens when the control register is written with the run bit clear. An update event zeroes the prescaler and the counter in either state.

Top module: `pwm_quad_timer`

## Requirements
- R1: With prescaler value P and reload value A active, the counter advances once every P+1 clocks, counts 0,1,...,A and then wraps to 0, so each output repeats every (P+1)*(A+1) clocks. The counter can be read at address 7.
- R2: In PWM mode the channel reference is high while count < compare. A compare of 0 keeps it low for the whole period, and a compare of A+1 keeps it high for the whole period. Compare k is at address 8+k.
- R3: The polarity bit inverts the main pin, so that pin is high from count = compare until the end of the period.
- R4: The complementary pin carries the inverse of the reference, XORed with its own polarity bit, and is gated by its own enable. Register CHCFG (address 3) holds one nibble per channel: bit 4k+0 enable, 4k+1 polarity, 4k+2 complementary enable, 4k+3 complementary polarity. In the variant without complementary pins (HAS_COMP=0), bits 4k+2 and 4k+3 read 0 and the complementary pins stay 0.
- R5: A pin is driven only while the main output enable (CTRL bit 2, address 0) is set, the state is RUN, and that pin's own enable is set. Otherwise the pin is 0.
- R6: With the reload-preload bit (CTRL bit 1) set, a write to RELOAD (address 2) takes effect only at the next wrap or update event. With the bit clear, the write takes effect at once. RELOAD always reads back the value written.
- R7: The prescaler value (address 1) and the compare values are always shadowed, and take effect only at a wrap or an update event.
- R8: Writing CTRL with bit 3 set is an update event. It loads every shadow value into its active register, and it zeroes the prescaler and the counter. Bit 3 always reads 0.
- R9: Each channel has an 8-bit mode lane. Channels 0 and 1 use MODE_A (address 4) bits [7:0] and [15:8]. Channels 2 and 3 use MODE_B (address 5) bits [7:0] and [15:8]. Code 0 forces the reference low, code 1 forces it high, code 2 selects PWM, and any other code forces it low.
- R10: After reset, every register reads 0, the counter is 0, the state is HALT, and all pins are 0.
- R11: Writing CTRL with bit 0 set takes the machine to RUN. Writing CTRL with bit 0 clear takes it to HALT, where the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DW (16) | Register write data |
| reg_rdata | output | DW (16) | Read data for reg_addr |
| pwm_out | output | NCH (4) | Main channel pins |
| pwm_out_n | output | NCH (4) | Complementary channel pins |

## Verification
The counter value and the active shadow copies are visible only through the counter readback and the pin levels. A wrong prescaler or reload value shows up within one period as a counter that reads back a different value or wraps at the wrong count. A compare copy loaded at the wrong time moves a pin edge within the same period. The bench keeps an independent cycle model driven by the same register writes and compares the counter and all eight pins at every clock. A fault in the state machine or in the gating therefore shows up on the first clock after the write that exposes it.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int AW = 4;

    localparam logic [AW-1:0] A_CTRL     = 4'h0;
    localparam logic [AW-1:0] A_PRESC    = 4'h1;
    localparam logic [AW-1:0] A_RELOAD   = 4'h2;
    localparam logic [AW-1:0] A_CHCFG    = 4'h3;
    localparam int            A_MODE_LO  = 4;
    localparam logic [AW-1:0] A_COUNT    = 4'h7;
    localparam int            A_CMP_BASE = 8;

    localparam logic [7:0] MD_FORCE_LOW  = 8'd0;
    localparam logic [7:0] MD_FORCE_HIGH = 8'd1;
    localparam logic [7:0] MD_PWM        = 8'd2;

    typedef enum logic [0:0] {
        TB_HALT = 1'b0,
        TB_RUN  = 1'b1
    } tb_state_e;

    typedef struct packed {
        logic cpol;
        logic cen;
        logic pol;
        logic en;
    } ch_cfg_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int CW       = 16,
    parameter int PW       = 16,
    parameter int DW       = 16,
    parameter bit HAS_COMP = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wdata,
    input  logic                      run_i,
    input  logic [CW-1:0]             cnt_i,
    output logic [DW-1:0]             rdata,
    output logic                      ctrl_wr,
    output logic                      run_req,
    output logic                      upd,
    output logic                      preload_en,
    output logic                      moe,
    output logic [PW-1:0]             psc_pre,
    output logic [CW-1:0]             arr_pre,
    output ch_cfg_t [NCH-1:0]         cfg,
    output logic [NCH-1:0][7:0]       mode,
    output logic [NCH-1:0][CW-1:0]    ccr_pre
);

    localparam logic [3:0] CFG_MASK = HAS_COMP ? 4'hF : 4'h3;

    logic                   pre_q, moe_q;
    logic [PW-1:0]          psc_q;
    logic [CW-1:0]          arr_q;
    ch_cfg_t [NCH-1:0]      cfg_q;
    logic [NCH-1:0][7:0]    mode_q;
    logic [NCH-1:0][CW-1:0] ccr_q;

    assign ctrl_wr = we && (addr == A_CTRL);
    assign run_req = wdata[0];
    assign upd     = ctrl_wr && wdata[3];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= 1'b0;
            moe_q  <= 1'b0;
            psc_q  <= '0;
            arr_q  <= '0;
            cfg_q  <= '0;
            mode_q <= '0;
            ccr_q  <= '0;
        end else if (we) begin
            case (addr)
                A_CTRL: begin
                    pre_q <= wdata[1];
                    moe_q <= wdata[2];
                end
                A_PRESC:  psc_q <= wdata[PW-1:0];
                A_RELOAD: arr_q <= wdata[CW-1:0];
                A_CHCFG: begin
                    for (int k = 0; k < NCH; k++) begin
                        cfg_q[k] <= ch_cfg_t'(wdata[4*k +: 4] & CFG_MASK);
                    end
                end
                default: ;
            endcase
            for (int k = 0; k < NCH; k++) begin
                if (addr == AW'(A_MODE_LO + k / 2)) begin
                    mode_q[k] <= wdata[8*(k%2) +: 8];
                end
                if (addr == AW'(A_CMP_BASE + k)) begin
                    ccr_q[k] <= wdata[CW-1:0];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata[2:0]    = {moe_q, pre_q, run_i};
            A_PRESC:  rdata[PW-1:0] = psc_q;
            A_RELOAD: rdata[CW-1:0] = arr_q;
            A_COUNT:  rdata[CW-1:0] = cnt_i;
            A_CHCFG: begin
                for (int k = 0; k < NCH; k++) begin
                    rdata[4*k +: 4] = cfg_q[k];
                end
            end
            default: ;
        endcase
        for (int k = 0; k < NCH; k++) begin
            if (addr == AW'(A_MODE_LO + k / 2)) begin
                rdata[8*(k%2) +: 8] = mode_q[k];
            end
            if (addr == AW'(A_CMP_BASE + k)) begin
                rdata[CW-1:0] = ccr_q[k];
            end
        end
    end

    assign preload_en = pre_q;
    assign moe        = moe_q;
    assign psc_pre    = psc_q;
    assign arr_pre    = arr_q;
    assign cfg        = cfg_q;
    assign mode       = mode_q;
    assign ccr_pre    = ccr_q;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_timer_pkg::*;
#(
    parameter int CW = 16,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic          run_req,
    input  logic          upd,
    input  logic          preload_en,
    input  logic [PW-1:0] psc_pre,
    input  logic [CW-1:0] arr_pre,
    output logic [CW-1:0] cnt,
    output logic          running,
    output logic          load
);

    tb_state_e     state_q, state_d;
    logic [PW-1:0] pc_q, psc_act;
    logic [CW-1:0] cnt_q, arr_act, arr_eff;
    logic          tick, wrap;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TB_HALT;
        else        state_q <= state_d;
    end

    // Transitions: GO and STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TB_HALT: if (ctrl_wr && run_req)  state_d = TB_RUN;
            TB_RUN:  if (ctrl_wr && !run_req) state_d = TB_HALT;
            default: state_d = TB_HALT;
        endcase
    end

    assign arr_eff = preload_en ? arr_act : arr_pre;
    assign tick    = (state_q == TB_RUN) && (pc_q >= psc_act);
    assign wrap    = tick && (cnt_q >= arr_eff);
    assign load    = upd || wrap;

    // Per-state datapath action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            cnt_q   <= '0;
            psc_act <= '0;
            arr_act <= '0;
        end else begin
            if (upd) begin
                pc_q  <= '0;
                cnt_q <= '0;
            end else begin
                unique case (state_q)
                    TB_RUN: begin
                        if (tick) begin
                            pc_q  <= '0;
                            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
                        end else begin
                            pc_q  <= pc_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (load) begin
                psc_act <= psc_pre;
                arr_act <= arr_pre;
            end
        end
    end

    assign cnt     = cnt_q;
    assign running = (state_q == TB_RUN);

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_timer_pkg::*;
#(
    parameter int CW       = 16,
    parameter bit HAS_COMP = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] ccr_pre,
    input  logic [CW-1:0] cnt,
    input  logic [7:0]    mode,
    input  ch_cfg_t       cfg,
    input  logic          running,
    input  logic          moe,
    output logic          out_p,
    output logic          out_n
);

    logic [CW-1:0] ccr_act;
    logic          ref_w;
    logic          gate;

    always_ff @(posedge clk) begin
        if (!rst_n)    ccr_act <= '0;
        else if (load) ccr_act <= ccr_pre;
    end

    always_comb begin
        case (mode)
            MD_FORCE_HIGH: ref_w = 1'b1;
            MD_PWM:        ref_w = ({1'b0, cnt} < {1'b0, ccr_act});
            default:       ref_w = 1'b0;
        endcase
    end

    assign gate  = moe && running;
    assign out_p = (gate && cfg.en) ? (ref_w ^ cfg.pol) : 1'b0;

    generate
        if (HAS_COMP) begin : g_comp
            assign out_n = (gate && cfg.cen) ? (~ref_w ^ cfg.cpol) : 1'b0;
        end else begin : g_nocomp
            assign out_n = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pwm_quad_timer.sv
module pwm_quad_timer
    import pwm_timer_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int CW       = 16,
    parameter int PW       = 16,
    parameter int DW       = 16,
    parameter bit HAS_COMP = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [3:0]     reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic [NCH-1:0] pwm_out,
    output logic [NCH-1:0] pwm_out_n
);

    logic                   ctrl_wr, run_req, upd_evt, preload_en, moe;
    logic                   tb_run, load_evt;
    logic [CW-1:0]          tb_cnt, arr_pre;
    logic [PW-1:0]          psc_pre;
    ch_cfg_t [NCH-1:0]      cfg;
    logic [NCH-1:0][7:0]    mode;
    logic [NCH-1:0][CW-1:0] ccr_pre;

    pwm_regs #(
        .NCH(NCH), .CW(CW), .PW(PW), .DW(DW), .HAS_COMP(HAS_COMP)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .run_i(tb_run), .cnt_i(tb_cnt),
        .rdata(reg_rdata), .ctrl_wr(ctrl_wr), .run_req(run_req),
        .upd(upd_evt), .preload_en(preload_en), .moe(moe),
        .psc_pre(psc_pre), .arr_pre(arr_pre), .cfg(cfg), .mode(mode),
        .ccr_pre(ccr_pre)
    );

    pwm_timebase #(.CW(CW), .PW(PW)) tbase_i (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .run_req(run_req),
        .upd(upd_evt), .preload_en(preload_en), .psc_pre(psc_pre),
        .arr_pre(arr_pre), .cnt(tb_cnt), .running(tb_run), .load(load_evt)
    );

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_ch
            pwm_channel #(.CW(CW), .HAS_COMP(HAS_COMP)) ch_i (
                .clk(clk), .rst_n(rst_n), .load(load_evt),
                .ccr_pre(ccr_pre[k]), .cnt(tb_cnt), .mode(mode[k]),
                .cfg(cfg[k]), .running(tb_run), .moe(moe),
                .out_p(pwm_out[k]), .out_n(pwm_out_n[k])
            );
        end
    endgenerate

endmodule

// File: rtl/pwm_quad_timer_chk.sv
module pwm_quad_timer_chk
    import pwm_timer_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [CW-1:0]     cnt,
    input logic              upd,
    input logic              moe,
    input ch_cfg_t [NCH-1:0] cfg,
    input logic [NCH-1:0]    pwm_out,
    input logic [NCH-1:0]    pwm_out_n
);

    assert_halt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !upd) |=> $stable(cnt))
        else $error("counter moved while halted");

    assert_update_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (cnt == '0))
        else $error("update event did not zero the counter");

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !upd) |=> ((cnt == '0) || (cnt == $past(cnt)) ||
                           (cnt == CW'($past(cnt) + 1'b1))))
        else $error("counter made an illegal step");

    assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!moe || !run) |-> ((pwm_out == '0) && (pwm_out_n == '0)))
        else $error("pin driven while gated");

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_pair
            assert_comp_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (moe && run && cfg[k].en && cfg[k].cen && (cfg[k].pol == cfg[k].cpol))
                |-> (pwm_out[k] != pwm_out_n[k]))
                else $error("complementary pair not opposite");
        end
    endgenerate

endmodule

bind pwm_quad_timer pwm_quad_timer_chk #(.NCH(NCH), .CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .run(tb_run), .cnt(tb_cnt), .upd(upd_evt),
    .moe(moe), .cfg(cfg), .pwm_out(pwm_out), .pwm_out_n(pwm_out_n)
);

// File: tb/pwm_quad_timer_tb_top.sv
module pwm_quad_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata, reg_rdata_nc;
    logic [3:0]  pwm_out, pwm_out_n, pwm_out_nc, pwm_out_n_nc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_quad_timer dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm_out(pwm_out), .pwm_out_n(pwm_out_n)
    );

    pwm_quad_timer #(.HAS_COMP(1'b0)) dut_nc_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata_nc),
        .pwm_out(pwm_out_nc), .pwm_out_n(pwm_out_n_nc)
    );

    // Independent cycle model built from the requirements
    logic        m_run, m_pre, m_moe, m_upd, m_tick, m_wrap, m_load;
    logic [15:0] m_pc, m_cnt, m_psc_act, m_arr_act, m_psc_pre, m_arr_pre, m_aeff;
    logic [3:0]  m_cfg [4];
    logic [7:0]  m_mode [4];
    logic [15:0] m_ccr_pre [4];
    logic [15:0] m_ccr_act [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_pre = 0; m_moe = 0; m_pc = 0; m_cnt = 0;
            m_psc_act = 0; m_arr_act = 0; m_psc_pre = 0; m_arr_pre = 0;
            for (int k = 0; k < 4; k++) begin
                m_cfg[k] = 0; m_mode[k] = 0; m_ccr_pre[k] = 0; m_ccr_act[k] = 0;
            end
        end else begin
            m_upd  = reg_we && (reg_addr == 4'h0) && reg_wdata[3];
            m_aeff = m_pre ? m_arr_act : m_arr_pre;
            m_tick = m_run && (m_pc >= m_psc_act);
            m_wrap = m_tick && (m_cnt >= m_aeff);
            m_load = m_upd || m_wrap;
            if (m_upd) begin
                m_pc = 0; m_cnt = 0;
            end else if (m_run) begin
                if (m_tick) begin
                    m_pc = 0;
                    m_cnt = m_wrap ? 16'd0 : m_cnt + 16'd1;
                end else begin
                    m_pc = m_pc + 16'd1;
                end
            end
            if (m_load) begin
                m_psc_act = m_psc_pre;
                m_arr_act = m_arr_pre;
                for (int k = 0; k < 4; k++) m_ccr_act[k] = m_ccr_pre[k];
            end
            if (reg_we) begin
                case (reg_addr)
                    4'h0: begin m_run = reg_wdata[0]; m_pre = reg_wdata[1]; m_moe = reg_wdata[2]; end
                    4'h1: m_psc_pre = reg_wdata;
                    4'h2: m_arr_pre = reg_wdata;
                    4'h3: for (int k = 0; k < 4; k++) m_cfg[k] = reg_wdata[4*k +: 4];
                    4'h4: begin m_mode[0] = reg_wdata[7:0]; m_mode[1] = reg_wdata[15:8]; end
                    4'h5: begin m_mode[2] = reg_wdata[7:0]; m_mode[3] = reg_wdata[15:8]; end
                    4'h8, 4'h9, 4'hA, 4'hB: m_ccr_pre[reg_addr - 4'h8] = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic ref_of(int k);
        if (m_mode[k] == 8'd1) return 1'b1;
        if (m_mode[k] == 8'd2) return (m_cnt < m_ccr_act[k]);
        return 1'b0;
    endfunction

    function automatic logic [3:0] exp_p();
        logic [3:0] v;
        for (int k = 0; k < 4; k++)
            v[k] = (m_moe && m_run && m_cfg[k][0]) ? (ref_of(k) ^ m_cfg[k][1]) : 1'b0;
        return v;
    endfunction

    function automatic logic [3:0] exp_n();
        logic [3:0] v;
        for (int k = 0; k < 4; k++)
            v[k] = (m_moe && m_run && m_cfg[k][2]) ? (~ref_of(k) ^ m_cfg[k][3]) : 1'b0;
        return v;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d, output logic [15:0] dnc);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1;
        d = reg_rdata; dnc = reg_rdata_nc;
    endtask

    task automatic run_check(int n, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            reg_we = 1'b0; reg_addr = 4'h7;
            #1;
            chk({tag, " count"}, reg_rdata, m_cnt);
            chk({tag, " pwm_out"}, pwm_out, exp_p());
            chk({tag, " pwm_out_n"}, pwm_out_n, exp_n());
        end
    endtask

    task automatic t_reset();
        logic [15:0] d, dn;
        rd(4'h0, d, dn); chk("R10 ctrl", d, 0);
        rd(4'h7, d, dn); chk("R10 count", d, 0);
        rd(4'h3, d, dn); chk("R10 chcfg", d, 0);
        chk("R10 pins", {pwm_out, pwm_out_n}, 0);
    endtask

    task automatic t_basic();
        int hi [4];
        logic [15:0] d, dn;
        wr(4'h1, 16'd0); wr(4'h2, 16'd9);
        wr(4'h8, 16'd3); wr(4'h9, 16'd0); wr(4'hA, 16'd10); wr(4'hB, 16'd7);
        wr(4'h4, 16'h0202); wr(4'h5, 16'h0202); wr(4'h3, 16'h1111);
        wr(4'h0, 16'h000F);
        for (int k = 0; k < 4; k++) hi[k] = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); reg_we = 1'b0; reg_addr = 4'h7; #1;
            for (int k = 0; k < 4; k++) hi[k] += pwm_out[k];
        end
        chk("R2 duty ch0 cmp3", hi[0], 3);
        chk("R2 duty ch1 cmp0", hi[1], 0);
        chk("R2 duty ch2 cmp=A+1", hi[2], 10);
        chk("R2 duty ch3 cmp7", hi[3], 7);
        rd(4'h0, d, dn); chk("R8 update bit reads 0", d, 16'h0007);
        run_check(25, "R2");
    endtask

    task automatic t_prescale();
        int t;
        logic prev;
        wr(4'h1, 16'd2);
        run_check(40, "R7");
        prev = pwm_out[3];
        t = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); reg_we = 1'b0; #1;
            if (!prev && pwm_out[3]) break;
            prev = pwm_out[3];
        end
        prev = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #1;
            t++;
            if (!prev && pwm_out[3]) break;
            prev = pwm_out[3];
        end
        chk("R1 period (P+1)(A+1)", t, 30);
    endtask

    task automatic t_polarity_comp();
        logic [15:0] d, dn;
        wr(4'h1, 16'd0);
        wr(4'h3, 16'h4D53);
        wr(4'h0, 16'h000F);
        run_check(30, "R3 R4");
        rd(4'h3, d, dn);
        chk("R4 chcfg full", d, 16'h4D53);
        chk("R4 chcfg no-comp variant", dn, 16'h0113);
        chk("R4 no-comp pins low", pwm_out_n_nc, 0);
        chk("R3 main pin high at count>=cmp", pwm_out[0], (m_cnt >= 16'd3));
    endtask

    task automatic t_preload();
        logic [15:0] d, dn;
        wr(4'h0, 16'h000F);
        wr(4'h2, 16'd4);
        run_check(25, "R6 shadowed");
        rd(4'h2, d, dn); chk("R6 reload readback", d, 16'd4);
        wr(4'h0, 16'h0005);
        wr(4'h2, 16'd12);
        run_check(30, "R6 direct");
    endtask

    task automatic t_compare_buf();
        wr(4'h2, 16'd9);
        wr(4'h0, 16'h000F);
        run_check(3, "R7");
        wr(4'h8, 16'd8);
        run_check(20, "R7 compare shadow");
    endtask

    task automatic t_mode();
        logic [15:0] d, dn;
        wr(4'h3, 16'h1111);
        wr(4'h4, 16'h0100);
        wr(4'h5, 16'h0702);
        run_check(15, "R9");
        chk("R9 forced high ch1", pwm_out[1], 1'b1);
        chk("R9 code7 low ch3", pwm_out[3], 1'b0);
        rd(4'h5, d, dn); chk("R9 MODE_B readback", d, 16'h0702);
    endtask

    task automatic t_gating();
        logic [15:0] d0, d1, dn;
        wr(4'h4, 16'h0101);
        wr(4'h3, 16'h5555);
        wr(4'h0, 16'h0003);
        run_check(8, "R5");
        chk("R5 moe off pins", {pwm_out, pwm_out_n}, 0);
        wr(4'h0, 16'h0004);
        run_check(8, "R11");
        rd(4'h7, d0, dn);
        repeat (5) @(negedge clk);
        rd(4'h7, d1, dn);
        chk("R11 halted count held", d1, d0);
        chk("R5 halted pins", {pwm_out, pwm_out_n}, 0);
    endtask

    task automatic t_update();
        logic [15:0] d, dn;
        wr(4'h4, 16'h0202);
        wr(4'h0, 16'h000D);
        rd(4'h0, d, dn); chk("R8 ctrl after update", d, 16'h0005);
        run_check(12, "R8");
        wr(4'h0, 16'h0004);
        wr(4'h0, 16'h000C);
        rd(4'h7, d, dn); chk("R8 update in HALT zeroes count", d, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_prescale();
        t_polarity_comp();
        t_preload();
        t_compare_buf();
        t_mode();
        t_gating();
        t_update();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule